// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

A 16-bit arithmetic and logic unit for a small processor core. One operation arrives per cycle: an operation code, a source and a destination operand, a byte/word select and the current carry flag. One clock later the block presents the result, a write-enable that says whether the result belongs in the destination, and the next values of the sign (N), zero (Z), carry (C) and overflow (V) flags.

The block covers binary addition with and without the incoming carry, subtraction done as destination plus inverted source plus one or plus carry, packed decimal addition, bitwise AND, OR, XOR and bit-clear, comparison and bit test that only produce flags, arithmetic and through-carry right shifts, byte swap and sign extension from bit 7. In byte mode only the low eight bits take part, the upper byte of the result is cleared and the flags are taken at bit 7. Operand fetch, stack handling and program flow lie outside it.

Top module: `bw_alu`

## Requirements
- R1: After reset `outValid`, `result`, `writeEn` and all four flags are 0; each input accepted with `inValid` high appears on the outputs exactly one clock later with `outValid` high, and an idle cycle gives `outValid` low one clock later.
- R2: Code 0 gives dst+src and code 1 gives dst+src+`carryIn`; C is the carry out of the top bit of the active width, V is set when both addends share a sign that the result does not.
- R3: Code 2 gives dst+NOT(src)+1 and code 3 gives dst+NOT(src)+`carryIn`; C is the carry out of that sum (1 means no borrow), V is set on signed overflow of that sum.
- R4: Code 4 (compare) produces the flags of code 2 and code 7 (bit test) produces the flags of code 6, and both drive `writeEn` low.
- R5: Code 5 adds src, dst and `carryIn` as packed decimal digits, low digit first; a digit sum above 9 is corrected by adding 6 and carries into the next digit; C is the carry out of the top digit of the active width and V is 0.
- R6: Codes 6 (AND), 8 (NOT(src) AND dst), 9 (OR) and 10 (XOR) combine the operands bitwise; for these and for codes 7, 13 and 14, C is the inverse of Z and V is 0.
- R7: Code 11 shifts dst right one bit keeping its top bit, code 12 shifts dst right with `carryIn` entering the top bit; in both the bit shifted out of bit 0 becomes C and V is 0.
- R8: Code 13 exchanges the two bytes of dst and code 14 copies bit 7 of dst into bits 8 to 15; both always work on the full word whatever `byteMode` says.
- R9: With `byteMode` high, all other operations use bits 7:0 of the operands, return bits 15:8 of the result as 0, and take carry, sign and overflow at bit 7.
- R10: For every code except 15, N equals the top bit of the result at the active width and Z is set exactly when the result is zero.
- R11: Code 15 is reserved: `writeEn` is 0, `result` is 0, N, Z and V are 0 and C equals `carryIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (0..15, see requirements) |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| byteMode | input | 1 | 1 selects byte width, 0 word width |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Outputs below carry a result |
| result | output | 16 | Operation result |
| writeEn | output | 1 | Result is to be stored in the destination |
| flagN | output | 1 | Next sign flag |
| flagZ | output | 1 | Next zero flag |
| flagC | output | 1 | Next carry flag |
| flagV | output | 1 | Next overflow flag |

## Verification
The only state is the output register, so any fault in decoding, operand selection, the adder carry chain or the decimal correction shows on the outputs in the very cycle after the offending operation, with nothing carried over to later cycles. A wrong width select shows as a non-zero upper byte or a carry taken at the wrong bit; a wrong strobe from the decoder shows as a stored compare or a flag rule broken for a whole group of codes. The bench therefore compares every output against a behavioural model on every clock, drives the carry, sign and overflow boundaries of both widths on purpose, and then sweeps random operands across all codes.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  localparam int OP_BITS = 4;

  typedef enum logic [OP_BITS-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRA  = 4'd11,
    OP_RRC  = 4'd12,
    OP_SWPB = 4'd13,
    OP_SXT  = 4'd14,
    OP_RSVD = 4'd15
  } op_e;

  typedef enum logic [3:0] {
    U_ADD, U_BCD, U_AND, U_BIC, U_OR, U_XOR,
    U_RRA, U_RRC, U_SWP, U_SXT, U_NONE
  } unit_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  typedef struct packed {
    unit_e unit;
    logic  invSrc;
    cin_e  cinSel;
    logic  narrow;
    logic  wr;
    logic  logicRule;
  } strobe_t;

endpackage

// File: rtl/bw_alu_ctrl.sv
module bw_alu_ctrl
  import bw_alu_pkg::*;
(
  input  logic [OP_BITS-1:0] op,
  input  logic               byteMode,
  output strobe_t            strobe
);

  always_comb begin
    strobe           = '0;
    strobe.unit      = U_NONE;
    strobe.cinSel    = CIN_ZERO;
    strobe.wr        = 1'b1;
    strobe.narrow    = byteMode;
    case (op_e'(op))
      OP_ADD:  strobe.unit = U_ADD;
      OP_ADDC: begin strobe.unit = U_ADD; strobe.cinSel = CIN_FLAG; end
      OP_SUB:  begin strobe.unit = U_ADD; strobe.invSrc = 1'b1; strobe.cinSel = CIN_ONE; end
      OP_SUBC: begin strobe.unit = U_ADD; strobe.invSrc = 1'b1; strobe.cinSel = CIN_FLAG; end
      OP_CMP:  begin
        strobe.unit = U_ADD; strobe.invSrc = 1'b1; strobe.cinSel = CIN_ONE; strobe.wr = 1'b0;
      end
      OP_DADD: strobe.unit = U_BCD;
      OP_AND:  begin strobe.unit = U_AND; strobe.logicRule = 1'b1; end
      OP_BIT:  begin strobe.unit = U_AND; strobe.logicRule = 1'b1; strobe.wr = 1'b0; end
      OP_BIC:  begin strobe.unit = U_BIC; strobe.logicRule = 1'b1; end
      OP_BIS:  begin strobe.unit = U_OR;  strobe.logicRule = 1'b1; end
      OP_XOR:  begin strobe.unit = U_XOR; strobe.logicRule = 1'b1; end
      OP_RRA:  strobe.unit = U_RRA;
      OP_RRC:  strobe.unit = U_RRC;
      OP_SWPB: begin strobe.unit = U_SWP; strobe.logicRule = 1'b1; strobe.narrow = 1'b0; end
      OP_SXT:  begin strobe.unit = U_SXT; strobe.logicRule = 1'b1; strobe.narrow = 1'b0; end
      default: begin strobe.unit = U_NONE; strobe.wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bw_alu_dp.sv
module bw_alu_dp
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  strobe_t          strobe,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             carryIn,
  output logic [WIDTH-1:0] res,
  output logic             nOut,
  output logic             zOut,
  output logic             cOut,
  output logic             vOut
);

  localparam int HALF   = WIDTH / 2;
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] bOp;
  logic             cin;
  logic [WIDTH:0]   sumWord;
  logic [HALF:0]    sumByte;
  logic [WIDTH-1:0] bcdSum;
  logic [DIGITS:0]  digitCarry;
  logic [WIDTH-1:0] raw;
  logic             rawCarry;
  logic             aTop, bTop, rTop;

  assign bOp = strobe.invSrc ? ~src : src;

  always_comb begin
    case (strobe.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryIn;
      default:  cin = 1'b0;
    endcase
  end

  assign sumWord = {1'b0, dst} + {1'b0, bOp} + {{WIDTH{1'b0}}, cin};
  assign sumByte = {1'b0, dst[HALF-1:0]} + {1'b0, bOp[HALF-1:0]} + {{HALF{1'b0}}, cin};

  assign digitCarry[0] = carryIn;
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] digitRaw;
    logic       fix;
    assign digitRaw = {1'b0, dst[4*g +: 4]} + {1'b0, src[4*g +: 4]} + {4'b0, digitCarry[g]};
    assign fix      = digitRaw > 5'd9;
    assign bcdSum[4*g +: 4] = fix ? (digitRaw[3:0] + 4'd6) : digitRaw[3:0];
    assign digitCarry[g+1]  = fix;
  end

  always_comb begin
    raw      = '0;
    rawCarry = 1'b0;
    case (strobe.unit)
      U_ADD: begin
        raw      = sumWord[WIDTH-1:0];
        rawCarry = strobe.narrow ? sumByte[HALF] : sumWord[WIDTH];
      end
      U_BCD: begin
        raw      = bcdSum;
        rawCarry = strobe.narrow ? digitCarry[DIGITS/2] : digitCarry[DIGITS];
      end
      U_AND: raw = src & dst;
      U_BIC: raw = ~src & dst;
      U_OR:  raw = src | dst;
      U_XOR: raw = src ^ dst;
      U_RRA: begin
        raw      = {dst[WIDTH-1], dst[WIDTH-1:1]};
        if (strobe.narrow) raw[HALF-1] = dst[HALF-1];
        rawCarry = dst[0];
      end
      U_RRC: begin
        raw      = {carryIn, dst[WIDTH-1:1]};
        if (strobe.narrow) raw[HALF-1] = carryIn;
        rawCarry = dst[0];
      end
      U_SWP: raw = {dst[HALF-1:0], dst[WIDTH-1:HALF]};
      U_SXT: raw = {{HALF{dst[HALF-1]}}, dst[HALF-1:0]};
      default: raw = '0;
    endcase
  end

  assign res  = strobe.narrow ? {{HALF{1'b0}}, raw[HALF-1:0]} : raw;
  assign aTop = strobe.narrow ? dst[HALF-1] : dst[WIDTH-1];
  assign bTop = strobe.narrow ? bOp[HALF-1] : bOp[WIDTH-1];
  assign rTop = strobe.narrow ? res[HALF-1] : res[WIDTH-1];

  always_comb begin
    nOut = rTop;
    zOut = (res == '0);
    cOut = rawCarry;
    vOut = (strobe.unit == U_ADD) && (aTop == bTop) && (rTop != aTop);
    if (strobe.logicRule) begin
      cOut = ~zOut;
      vOut = 1'b0;
    end
    if (strobe.unit == U_NONE) begin
      nOut = 1'b0;
      zOut = 1'b0;
      cOut = carryIn;
      vOut = 1'b0;
    end
  end

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OP_BITS-1:0] op,
  input  logic [WIDTH-1:0]   src,
  input  logic [WIDTH-1:0]   dst,
  input  logic               byteMode,
  input  logic               carryIn,
  output logic               outValid,
  output logic [WIDTH-1:0]   result,
  output logic               writeEn,
  output logic               flagN,
  output logic               flagZ,
  output logic               flagC,
  output logic               flagV
);

  strobe_t          strobe;
  logic [WIDTH-1:0] dpRes;
  logic             dpN, dpZ, dpC, dpV;

  bw_alu_ctrl u_ctrl (
    .op       (op),
    .byteMode (byteMode),
    .strobe   (strobe)
  );

  bw_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .strobe  (strobe),
    .src     (src),
    .dst     (dst),
    .carryIn (carryIn),
    .res     (dpRes),
    .nOut    (dpN),
    .zOut    (dpZ),
    .cOut    (dpC),
    .vOut    (dpV)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      writeEn  <= 1'b0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagC    <= 1'b0;
      flagV    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= dpRes;
        writeEn <= strobe.wr;
        flagN   <= dpN;
        flagZ   <= dpZ;
        flagC   <= dpC;
        flagV   <= dpV;
      end
    end
  end

endmodule

// File: rtl/bw_alu_checker.sv
module bw_alu_checker
  import bw_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [OP_BITS-1:0] op,
  input logic [WIDTH-1:0]   src,
  input logic [WIDTH-1:0]   dst,
  input logic               byteMode,
  input logic               carryIn,
  input logic               outValid,
  input logic [WIDTH-1:0]   result,
  input logic               writeEn,
  input logic               flagN,
  input logic               flagZ,
  input logic               flagC,
  input logic               flagV
);

  localparam int HALF = WIDTH / 2;

  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (!rstN)
    outValid && ($past(op) == OP_CMP || $past(op) == OP_BIT) |-> !writeEn);

  a_r9_upper_cleared: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(byteMode) && $past(op) != OP_SWPB && $past(op) != OP_SXT
    |-> result[WIDTH-1:HALF] == '0);

  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && writeEn |-> flagZ == (result == '0));

  a_r10_sign_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid && writeEn && !$past(byteMode) |-> flagN == result[WIDTH-1]);

  a_r6_logic_flags: assert property (@(posedge clk) disable iff (!rstN)
    outValid && ($past(op) == OP_AND || $past(op) == OP_BIC ||
                 $past(op) == OP_BIS || $past(op) == OP_XOR)
    |-> !flagV && (flagC != flagZ));

  a_r8_sign_extend: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(op) == OP_SXT |-> result[WIDTH-1:HALF] == {HALF{result[HALF-1]}});

  a_r11_reserved: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(op) == OP_RSVD |-> !writeEn && result == '0 && flagC == $past(carryIn));

endmodule

bind bw_alu bw_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .op       (op),
  .src      (src),
  .dst      (dst),
  .byteMode (byteMode),
  .carryIn  (carryIn),
  .outValid (outValid),
  .result   (result),
  .writeEn  (writeEn),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .flagC    (flagC),
  .flagV    (flagV)
);

// File: tb/tb_bw_alu.sv
module tb_bw_alu;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] src = '0;
  logic [15:0] dst = '0;
  logic        byteMode = 1'b0;
  logic        carryIn = 1'b0;
  logic        outValid;
  logic [15:0] result;
  logic        writeEn;
  logic        flagN, flagZ, flagC, flagV;

  int checks = 0;
  int errors = 0;

  bit          pendValid = 1'b0;
  logic [20:0] pendExp = '0;
  string       pendTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .src(src), .dst(dst),
    .byteMode(byteMode), .carryIn(carryIn), .outValid(outValid), .result(result),
    .writeEn(writeEn), .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  // expected {writeEn, N, Z, C, V, result}
  function automatic logic [20:0] model(int o, int s, int d, bit bm, bit ci);
    int w, mask, sign, a, b, r, c, v, we, n, z, bb, cin, sum, cc, t;
    bit lr;
    w    = (bm && o != 13 && o != 14) ? 8 : 16;
    mask = (1 << w) - 1;
    sign = 1 << (w - 1);
    a = d & mask; b = s & mask;
    r = 0; c = 0; v = 0; we = 1; lr = 0;
    case (o)
      0, 1, 2, 3, 4: begin
        bb  = (o >= 2) ? ((~b) & mask) : b;
        cin = (o == 0) ? 0 : (o == 2 || o == 4) ? 1 : int'(ci);
        sum = a + bb + cin;
        r   = sum & mask;
        c   = (sum >> w) & 1;
        v   = (((a & sign) == (bb & sign)) && ((r & sign) != (a & sign))) ? 1 : 0;
        we  = (o == 4) ? 0 : 1;
      end
      5: begin
        cc = int'(ci);
        for (int i = 0; i < w / 4; i++) begin
          t = ((a >> (4*i)) & 15) + ((b >> (4*i)) & 15) + cc;
          if (t > 9) begin t = t + 6; cc = 1; end else cc = 0;
          r = r | ((t & 15) << (4*i));
        end
        c = cc;
      end
      6:  begin r = a & b; lr = 1; end
      7:  begin r = a & b; lr = 1; we = 0; end
      8:  begin r = (~b) & a & mask; lr = 1; end
      9:  begin r = a | b; lr = 1; end
      10: begin r = a ^ b; lr = 1; end
      11: begin r = (a >> 1) | (a & sign); c = a & 1; end
      12: begin r = (a >> 1) | (ci ? sign : 0); c = a & 1; end
      13: begin r = ((d & 255) << 8) | ((d >> 8) & 255); lr = 1; end
      14: begin r = ((d & 128) != 0) ? ((d & 255) | 32'hFF00) : (d & 255); lr = 1; end
      default: begin we = 0; r = 0; c = int'(ci); end
    endcase
    n = ((r & sign) != 0) ? 1 : 0;
    z = (r == 0) ? 1 : 0;
    if (lr) begin c = z ? 0 : 1; v = 0; end
    if (o == 15) begin n = 0; z = 0; end
    return {we[0], n[0], z[0], c[0], v[0], r[15:0]};
  endfunction

  function automatic string tagOf(int o, bit bm);
    if (bm && o != 13 && o != 14 && o != 15) return "R9";
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 7: return "R4";
      5: return "R5";
      6, 8, 9, 10: return "R6";
      11, 12: return "R7";
      13, 14: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic checkPending();
    logic [21:0] got, exp;
    checks++;
    if (pendValid) begin
      got = {outValid, writeEn, flagN, flagZ, flagC, flagV, result};
      exp = {1'b1, pendExp};
    end else begin
      got = {outValid, 21'b0};
      exp = 22'b0;
    end
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got v/we/NZCV/res=%h expected %h", pendTag, got, exp);
    end
  endtask

  task automatic step(bit v, int o, int s, int d, bit bm, bit ci, string tag);
    @(negedge clk);
    checkPending();
    inValid  = v;
    op       = o[3:0];
    src      = s[15:0];
    dst      = d[15:0];
    byteMode = bm;
    carryIn  = ci;
    pendValid = v;
    pendExp   = model(o, s, d, bm, ci);
    pendTag   = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({outValid, writeEn, flagN, flagZ, flagC, flagV, result} !== 22'b0) begin
      errors++;
      $display("FAIL R1 reset got %h expected 0",
               {outValid, writeEn, flagN, flagZ, flagC, flagV, result});
    end
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1");
    // R2: add boundaries
    step(1, 0, 16'h0001, 16'h7FFF, 0, 0, "R2");
    step(1, 0, 16'h0001, 16'hFFFF, 0, 1, "R2");
    step(1, 1, 16'h0001, 16'h0001, 0, 1, "R2");
    // R3: subtract boundaries
    step(1, 2, 16'h0003, 16'h0005, 0, 0, "R3");
    step(1, 2, 16'h0005, 16'h0003, 0, 0, "R3");
    step(1, 3, 16'h0003, 16'h0005, 0, 0, "R3");
    step(1, 2, 16'h0001, 16'h8000, 0, 0, "R3");
    // R4: flags only
    step(1, 4, 16'h0005, 16'h0005, 0, 0, "R4");
    step(1, 7, 16'h000F, 16'h00F0, 0, 1, "R4");
    // R5: decimal
    step(1, 5, 16'h0001, 16'h1999, 0, 0, "R5");
    step(1, 5, 16'h0001, 16'h9999, 0, 0, "R5");
    step(1, 5, 16'h0055, 16'h0045, 1, 1, "R5");
    // idle cycle between operations (R1)
    step(0, 0, 0, 0, 0, 0, "R1");
    // R6: logic group
    step(1, 6, 16'hF0F0, 16'h0FF0, 0, 0, "R6");
    step(1, 8, 16'hFFFF, 16'h1234, 0, 1, "R6");
    step(1, 9, 16'h8000, 16'h0001, 0, 0, "R6");
    step(1, 10, 16'hA5A5, 16'hA5A5, 0, 0, "R6");
    // R7: shifts
    step(1, 11, 0, 16'h8001, 0, 0, "R7");
    step(1, 12, 0, 16'h0002, 0, 1, "R7");
    step(1, 12, 0, 16'h0081, 1, 1, "R7");
    // R8: word-only ops with byteMode set
    step(1, 13, 0, 16'h12FF, 1, 0, "R8");
    step(1, 14, 0, 16'h3480, 1, 0, "R8");
    step(1, 14, 0, 16'hFF7F, 0, 0, "R8");
    // R9: byte width
    step(1, 0, 16'h3401, 16'h12FF, 1, 0, "R9");
    step(1, 2, 16'h0001, 16'h0080, 1, 0, "R9");
    step(1, 11, 0, 16'hFF80, 1, 0, "R9");
    // R11: reserved code
    step(1, 15, 16'h1234, 16'h5678, 0, 1, "R11");
    step(1, 15, 16'hFFFF, 16'hFFFF, 1, 0, "R11");
    // R10 and every code: random sweep
    for (int k = 0; k < 600; k++) begin
      int o;
      bit bm;
      o  = int'($urandom_range(0, 15));
      bm = 1'($urandom);
      step(1, o, int'($urandom & 16'hFFFF), int'($urandom & 16'hFFFF), bm, 1'($urandom),
           (k % 2 == 0) ? "R10" : tagOf(o, bm));
    end
    step(0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule